// File: doc/BRIEF.md
# Multi-Source Clock Mode Selector

This block produces the system clock enable for a core. Two oscillators feed it: a fast main oscillator and a slow sub oscillator. Each arrives as a one-cycle tick strobe in the fabric clock domain, one tick per oscillator period. A mode register chooses the source and the divide ratio. The choices are main divided by eight, main divided by two, and sub divided by two. The block also drives the enable lines of both oscillator cells. The main oscillator can be shut down to save power, but only while the system runs from the sub oscillator.

Software writes one 8-bit control word. The block refuses any combination that would leave the system without a running source. A requested ratio takes effect only when the current divided period ends, so the output never has a shortened period. Leaving reset gives the divide-by-eight main mode, with the sub oscillator off.

Top module: `clk_mode_sel`

## Requirements
- R1: While reset is asserted and right after it is released, the active mode is main divided by 8. In that state mainOscEn is 1, subOscEn is 0 and sysClkEn is 0.
- R2: In main-divide-by-8 mode (field value 10), sysClkEn pulses once per 8 accepted main ticks.
- R3: In main-divide-by-2 mode (field value 00), sysClkEn pulses once per 2 accepted main ticks.
- R4: In sub-divide-by-2 mode (field value 01), sysClkEn pulses once per 2 accepted sub ticks. Main ticks have no effect in this mode.
- R5: The control word has the mode in bits [7:6], the main-stop request in bit 5 and the sub-oscillator enable in bit 4. Mode field value 11 is reserved, and writing it leaves the mode unchanged.
- R6: A request for mode 01 is ignored unless the sub oscillator is enabled after the same write.
- R7: A request for mode 00 or 10 is ignored while the main-stop bit is set, or when the same write sets it.
- R8: The main-stop bit is accepted only when the selected mode is 01. mainOscEn falls only once mode 01 is actually active. Clearing the bit raises mainOscEn on the next cycle.
- R9: A mode change waits for the end of the current divided period. That period completes at the old ratio, and the next one starts at the new ratio from zero.
- R10: Clearing the sub enable is ignored while mode 01 is selected or active. subOscEn stays 1 whenever mode 01 is active.
- R11: sysClkEn is high for exactly one cycle. It rises on the cycle after the tick that completes a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Control word write strobe |
| wrData | input | 8 | Control word: mode [7:6], main stop [5], sub enable [4] |
| mainTick | input | 1 | One pulse per main oscillator period |
| subTick | input | 1 | One pulse per sub oscillator period |
| mainOscEn | output | 1 | Enable for the main oscillator cell |
| subOscEn | output | 1 | Enable for the sub oscillator cell |
| sysClkEn | output | 1 | System clock enable, one pulse per divided period |

## Verification
The bench writes a mode change part way through a long divide-by-8 period. A design that switched at once would emit a pulse early, and one that kept the old ratio would miss the later pulses. It tries to stop the main oscillator while the selected mode still uses it, and it tries to return to a main mode while main is stopped. A design that let either through would lose its clock source, which shows up as a missing pulse or a wrong enable level. It drives main ticks while the sub source is active, and it tries to clear the sub enable in that mode; a design that accepts either would emit extra pulses or drop subOscEn. A reserved mode write and a sub-mode request with the sub oscillator disabled must both leave the pulse rate as it was.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;

  localparam int REG_W    = 8;
  localparam int MODE_LSB = 6;
  localparam int STOP_BIT = 5;
  localparam int SUB_BIT  = 4;

  typedef enum logic [1:0] {
    MODE_HIGH = 2'b00,
    MODE_LOW  = 2'b01,
    MODE_MID  = 2'b10,
    MODE_RSVD = 2'b11
  } clk_mode_e;

  // control -> datapath
  typedef struct packed {
    clk_mode_e activeMode;
    logic      mainGate;
    logic      subGate;
  } ctrl_strobe_t;

endpackage

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
  import clk_mode_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [REG_W-1:0]    wrData,
  input  logic                periodEnd,
  output ctrl_strobe_t        strb,
  output logic                mainOscEn,
  output logic                subOscEn
);

  clk_mode_e targetQ, activeQ;
  logic      stopQ, subQ;

  clk_mode_e reqMode, newTarget;
  logic      reqStop, reqSub, reqMain, newSub, newStop;

  always_comb begin
    reqMode = clk_mode_e'(wrData[MODE_LSB +: 2]);
    reqStop = wrData[STOP_BIT];
    reqSub  = wrData[SUB_BIT];
    reqMain = (reqMode == MODE_HIGH) || (reqMode == MODE_MID);
    // sub enable may only drop when nothing depends on the sub source
    newSub  = reqSub || (targetQ == MODE_LOW) || (activeQ == MODE_LOW);
    if (reqMain && !(stopQ || reqStop))
      newTarget = reqMode;
    else if ((reqMode == MODE_LOW) && newSub)
      newTarget = MODE_LOW;
    else
      newTarget = targetQ;
    newStop = reqStop && (newTarget == MODE_LOW);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      targetQ <= MODE_MID;
      activeQ <= MODE_MID;
      stopQ   <= 1'b0;
      subQ    <= 1'b0;
    end else begin
      if (wrEn) begin
        targetQ <= newTarget;
        stopQ   <= newStop;
        subQ    <= newSub;
      end
      if (periodEnd)
        activeQ <= targetQ;
    end
  end

  always_comb begin
    mainOscEn       = !(stopQ && (activeQ == MODE_LOW));
    subOscEn        = subQ || (activeQ == MODE_LOW);
    strb.activeMode = activeQ;
    strb.mainGate   = mainOscEn;
    strb.subGate    = subOscEn;
  end

endmodule

// File: rtl/clkmode_dp.sv
module clkmode_dp
  import clk_mode_pkg::*;
#(
  parameter int DIV_MID  = 8,
  parameter int DIV_HIGH = 2,
  parameter int DIV_LOW  = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         mainTick,
  input  logic         subTick,
  input  ctrl_strobe_t strb,
  output logic         periodEnd,
  output logic         sysClkEn
);

  localparam int DIV_MAX = (DIV_MID > DIV_HIGH) ?
                           ((DIV_MID > DIV_LOW) ? DIV_MID : DIV_LOW) :
                           ((DIV_HIGH > DIV_LOW) ? DIV_HIGH : DIV_LOW);
  localparam int CNT_W   = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;

  localparam logic [CNT_W-1:0] LAST_MID  = CNT_W'(DIV_MID - 1);
  localparam logic [CNT_W-1:0] LAST_HIGH = CNT_W'(DIV_HIGH - 1);
  localparam logic [CNT_W-1:0] LAST_LOW  = CNT_W'(DIV_LOW - 1);

  logic [CNT_W-1:0] cntQ, lastCnt;
  logic             selTick, pulseQ;

  always_comb begin
    unique case (strb.activeMode)
      MODE_LOW:  begin selTick = subTick  && strb.subGate;  lastCnt = LAST_LOW;  end
      MODE_HIGH: begin selTick = mainTick && strb.mainGate; lastCnt = LAST_HIGH; end
      default:   begin selTick = mainTick && strb.mainGate; lastCnt = LAST_MID;  end
    endcase
    periodEnd = selTick && (cntQ == lastCnt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ   <= '0;
      pulseQ <= 1'b0;
    end else begin
      if (periodEnd)
        cntQ <= '0;
      else if (selTick)
        cntQ <= cntQ + 1'b1;
      pulseQ <= periodEnd;
    end
  end

  assign sysClkEn = pulseQ;

endmodule

// File: rtl/clk_mode_sel.sv
module clk_mode_sel
  import clk_mode_pkg::*;
#(
  parameter int DIV_MID  = 8,
  parameter int DIV_HIGH = 2,
  parameter int DIV_LOW  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             mainTick,
  input  logic             subTick,
  output logic             mainOscEn,
  output logic             subOscEn,
  output logic             sysClkEn
);

  ctrl_strobe_t strb;
  logic         periodEnd;

  clkmode_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .periodEnd (periodEnd),
    .strb      (strb),
    .mainOscEn (mainOscEn),
    .subOscEn  (subOscEn)
  );

  clkmode_dp #(
    .DIV_MID  (DIV_MID),
    .DIV_HIGH (DIV_HIGH),
    .DIV_LOW  (DIV_LOW)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .mainTick  (mainTick),
    .subTick   (subTick),
    .strb      (strb),
    .periodEnd (periodEnd),
    .sysClkEn  (sysClkEn)
  );

endmodule

// File: rtl/clk_mode_sel_chk.sv
module clk_mode_sel_chk (
  input logic clk,
  input logic rstN,
  input logic wrEn,
  input logic mainTick,
  input logic subTick,
  input logic mainOscEn,
  input logic subOscEn,
  input logic sysClkEn
);

  // R11
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysClkEn |=> !sysClkEn);

  // R11
  pulse_after_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysClkEn) |-> $past(mainTick || subTick));

  // R8
  stop_needs_sub_chk: assert property (@(posedge clk) disable iff (!rstN)
    !mainOscEn |-> subOscEn);

  // R4
  main_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!mainOscEn && !subTick) |=> !sysClkEn);

  // R8
  main_en_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> (sysClkEn || $stable(mainOscEn)));

  // R10
  sub_en_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> (sysClkEn || $stable(subOscEn)));

endmodule

bind clk_mode_sel clk_mode_sel_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .mainTick  (mainTick),
  .subTick   (subTick),
  .mainOscEn (mainOscEn),
  .subOscEn  (subOscEn),
  .sysClkEn  (sysClkEn)
);

// File: tb/clk_mode_sel_bench.sv
module clk_mode_sel_bench;

  typedef struct packed {
    logic       doWr;
    logic [7:0] data;
    logic [7:0] nMain;
    logic [7:0] nSub;
    logic [7:0] expPulse;
    logic       expMainEn;
    logic       expSubEn;
  } vec_t;

  // write, main ticks, sub ticks, pulses expected, oscillator enables after
  localparam vec_t VECS [0:11] = '{
    '{1'b0, 8'h00, 8'd16, 8'd0, 8'd2, 1'b1, 1'b0},  // R2 divide by 8
    '{1'b1, 8'h00, 8'd8,  8'd0, 8'd1, 1'b1, 1'b0},  // R9 old ratio finishes
    '{1'b0, 8'h00, 8'd6,  8'd0, 8'd3, 1'b1, 1'b0},  // R3 divide by 2
    '{1'b1, 8'h40, 8'd4,  8'd4, 8'd2, 1'b1, 1'b0},  // R6 sub mode w/o sub enable
    '{1'b1, 8'h50, 8'd2,  8'd4, 8'd3, 1'b1, 1'b1},  // R4 R9 switch to sub
    '{1'b1, 8'h10, 8'd4,  8'd2, 8'd1, 1'b1, 1'b1},  // R4 main ticks ignored
    '{1'b1, 8'h30, 8'd4,  8'd0, 8'd2, 1'b1, 1'b1},  // R7 R8 stop in main mode
    '{1'b1, 8'h70, 8'd4,  8'd4, 8'd3, 1'b0, 1'b1},  // R8 stop accepted
    '{1'b1, 8'h00, 8'd4,  8'd2, 8'd1, 1'b1, 1'b1},  // R7 R10 main while stopped
    '{1'b1, 8'h10, 8'd2,  8'd2, 8'd1, 1'b1, 1'b1},  // R9 back to main
    '{1'b1, 8'hD0, 8'd4,  8'd0, 8'd2, 1'b1, 1'b1},  // R5 reserved mode
    '{1'b1, 8'h80, 8'd10, 8'd0, 8'd2, 1'b1, 1'b0}   // R5 R10 middle, sub off
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       mainTick = 1'b0;
  logic       subTick = 1'b0;
  logic       mainOscEn, subOscEn, sysClkEn;

  int total = 0;
  int bad = 0;
  int pulseCnt = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  clk_mode_sel u_clk_mode_sel (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .mainTick  (mainTick),
    .subTick   (subTick),
    .mainOscEn (mainOscEn),
    .subOscEn  (subOscEn),
    .sysClkEn  (sysClkEn)
  );

  always @(negedge clk)
    if (rstN && sysClkEn) pulseCnt++;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // oscillator models honour their enables
  task automatic drvTicks(input int nM, input int nS);
    for (int i = 0; i < nM; i++) begin
      @(negedge clk);
      mainTick = mainOscEn;
      @(negedge clk);
      mainTick = 1'b0;
    end
    for (int i = 0; i < nS; i++) begin
      @(negedge clk);
      subTick = subOscEn;
      @(negedge clk);
      subTick = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 mainOscEn", int'(mainOscEn), 1);
    check("R1 subOscEn", int'(subOscEn), 0);
    check("R1 sysClkEn", int'(sysClkEn), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 sysClkEn after release", int'(sysClkEn), 0);

    for (int v = 0; v < 12; v++) begin
      if (VECS[v].doWr) wrReg(VECS[v].data);
      base = pulseCnt;
      drvTicks(int'(VECS[v].nMain), int'(VECS[v].nSub));
      check($sformatf("vector %0d pulses", v), pulseCnt - base, int'(VECS[v].expPulse));
      check($sformatf("vector %0d mainOscEn", v), int'(mainOscEn), int'(VECS[v].expMainEn));
      check($sformatf("vector %0d subOscEn", v), int'(subOscEn), int'(VECS[v].expSubEn));
    end

    // R8: stop requested from middle mode holds main on until the switch
    wrReg(8'h70);
    check("R8 main still on before boundary", int'(mainOscEn), 1);
    check("R10 sub on", int'(subOscEn), 1);
    base = pulseCnt;
    drvTicks(8, 0);
    check("R8 main off after boundary", int'(mainOscEn), 0);
    check("R2 one pulse at old ratio", pulseCnt - base, 1);

    // R11: pulse timing in sub mode, counter at zero
    @(negedge clk); subTick = 1'b1;
    @(negedge clk); subTick = 1'b0;
    check("R11 no pulse mid period", int'(sysClkEn), 0);
    @(negedge clk); subTick = 1'b1;
    @(negedge clk); subTick = 1'b0;
    check("R11 pulse one cycle after tick", int'(sysClkEn), 1);
    @(negedge clk);
    check("R11 pulse one cycle wide", int'(sysClkEn), 0);

    // R1: reset in the middle of operation
    rstN = 1'b0;
    @(negedge clk);
    check("R1 mainOscEn after reset", int'(mainOscEn), 1);
    check("R1 subOscEn after reset", int'(subOscEn), 0);
    rstN = 1'b1;
    base = pulseCnt;
    drvTicks(8, 0);
    check("R1 R2 middle after reset", pulseCnt - base, 1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule